// File: doc/BRIEF.md
# Block-Gated Capture Delay Memory

This block records a sequential stream of multi-bit converter samples without random access. To the outside it behaves as one long delay line: each enabled clock cycle one sample goes in and the sample captured a fixed number of enabled cycles earlier comes out. Inside, the storage is split into several equal banks. Each bank is a chain of flip-flop stages per data bit, built from a parameterised number of segments. On any cycle only one bank shifts. A single shared bank pointer chooses that bank, and a programmable divider steps the pointer, so every other bank's registers stay still.

The output is taken from the last stage of the bank the pointer selects, just before that bank shifts, and passes through one output register. The bank pointer and the storage have no reset. The design works from any pointer value. A capture-enable input freezes the whole memory so a recorded stream can be read out slowly.

Top module: `gsr_capture_mem`

## Requirements
- R1: With `step_div` held at a value that divides SEG_LEN*SEG_CNT (32 by default), `dout` after the k-th enabled clock edge equals the `din` sampled at enabled edge k-DEPTH. DEPTH = SEG_LEN*SEG_CNT*BANKS (256 by default). This holds from any starting bank pointer and divider phase.
- R2: `step_div` selects how many enabled cycles the pointer rests on each bank. Every legal value from 1 up to BANKS (1, 2, 4, 8 by default) gives the same delay DEPTH.
- R3: A `step_div` value of 0 behaves exactly like 1, and values above BANKS behave like BANKS.
- R4: While `cap_en` is low, `dout`, the bank pointer and every stored sample keep their values. The delay of R1 counts enabled edges only.
- R5: A synchronous active-high `rst` clears `dout` to 0 and the divider phase. It does not clear the stored samples or the bank pointer.
- R6: On any edge at most one bank shifts: the bank whose index equals the pointer, and only while `cap_en` is high. Every other bank holds its tail value.
- R7: The bank pointer either stays put or advances by one, and wraps from BANKS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset of output register and divider |
| cap_en | input | 1 | Capture enable; low freezes all state |
| step_div | input | $clog2(BANKS+1) | Enabled cycles per bank visit (0 acts as 1) |
| din | input | WIDTH | Sample written this cycle |
| dout | output | WIDTH | Sample written DEPTH enabled cycles earlier |

## Verification
The bench compares the output with its own 256-deep history for every divider value that divides the bank length, plus the value 0. Before each run it shifts the pointer phase with a varying number of throwaway cycles. A design that read the tail after the shift, or that let an idle bank move, would show a delay off by one or by a whole bank visit for some divider values only. Mid-stream stalls check that a frozen memory neither moves its output nor loses its place in the stream. Resets issued before and after data is captured confirm that only the output register clears.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  // Clamp a requested per-bank dwell count into the legal range 1..banks.
  function automatic int unsigned dwell_limit(input int unsigned req,
                                              input int unsigned banks);
    if (req == 0)     return 1;
    if (req > banks)  return banks;
    return req;
  endfunction

endpackage

// File: rtl/gsr_addr_ctl.sv
module gsr_addr_ctl #(
  parameter int unsigned BANKS = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned RW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [RW-1:0] step_div,
  output logic [AW-1:0] bank_ptr
);
  import gsr_pkg::*;

  localparam logic [AW-1:0] LAST_BANK = AW'(BANKS - 1);

  logic [RW-1:0] dwell_q;
  logic [RW-1:0] dwell_lim;
  logic          advance;

  always_comb begin
    dwell_lim = RW'(dwell_limit(int'(step_div), BANKS));
    advance   = (dwell_q >= dwell_lim - RW'(1));
  end

  // Divider phase: the only state here with a reset.
  always_ff @(posedge clk) begin
    if (rst)          dwell_q <= '0;
    else if (cap_en)  dwell_q <= advance ? '0 : dwell_q + RW'(1);
  end

  // Bank pointer: no reset, any start value is usable.
  always_ff @(posedge clk) begin
    if (cap_en && advance)
      bank_ptr <= (bank_ptr >= LAST_BANK) ? '0 : bank_ptr + AW'(1);
  end

  // R4
  ptr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(bank_ptr));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> ($stable(bank_ptr) ||
                bank_ptr == (($past(bank_ptr) == LAST_BANK) ? AW'(0)
                                                           : $past(bank_ptr) + AW'(1))));

endmodule

// File: rtl/gsr_bank.sv
module gsr_bank #(
  parameter int unsigned WIDTH   = 12,
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned SEG_CNT = 2,
  parameter int unsigned AW      = 3,
  parameter int unsigned IDX     = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [AW-1:0]    bank_ptr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tail,
  output logic             shift_en
);

  // Segment boundaries: link[0] is the bank input, link[g+1] the end of segment g.
  logic [SEG_CNT:0][WIDTH-1:0] link;

  assign shift_en = cap_en && (bank_ptr == AW'(IDX));
  assign link[0]  = din;
  assign tail     = link[SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    logic [SEG_LEN-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
      if (shift_en) begin
        stage_q[0] <= link[g];
        for (int s = 1; s < SEG_LEN; s++)
          stage_q[s] <= stage_q[s-1];
      end
    end

    assign link[g+1] = stage_q[SEG_LEN-1];
  end

  // R6
  idle_bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(tail));

endmodule

// File: rtl/gsr_outmux.sv
module gsr_outmux #(
  parameter int unsigned WIDTH = 12,
  parameter int unsigned BANKS = 8,
  parameter int unsigned AW    = 3
) (
  input  logic [BANKS-1:0][WIDTH-1:0] tails,
  input  logic [AW-1:0]               bank_ptr,
  output logic [WIDTH-1:0]            sel_tail
);
  localparam int unsigned SLOTS = 1 << AW;

  logic [SLOTS-1:0][WIDTH-1:0] padded;

  for (genvar i = 0; i < SLOTS; i++) begin : g_pad
    if (i < BANKS) begin : g_real
      assign padded[i] = tails[i];
    end else begin : g_fill
      assign padded[i] = '0;
    end
  end

  assign sel_tail = padded[bank_ptr];

endmodule

// File: rtl/gsr_capture_mem.sv
module gsr_capture_mem #(
  parameter int unsigned WIDTH   = 12,
  parameter int unsigned SEG_LEN = 16,
  parameter int unsigned SEG_CNT = 2,
  parameter int unsigned BANKS   = 8,
  localparam int unsigned AW     = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned RW     = $clog2(BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic [RW-1:0]    step_div,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [AW-1:0]               bank_ptr;
  logic [BANKS-1:0][WIDTH-1:0] tails;
  logic [BANKS-1:0]            shift_vec;
  logic [WIDTH-1:0]            sel_tail;

  gsr_addr_ctl #(.BANKS(BANKS), .AW(AW), .RW(RW)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .step_div (step_div),
    .bank_ptr (bank_ptr)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gsr_bank #(
      .WIDTH   (WIDTH),
      .SEG_LEN (SEG_LEN),
      .SEG_CNT (SEG_CNT),
      .AW      (AW),
      .IDX     (b)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .bank_ptr (bank_ptr),
      .din      (din),
      .tail     (tails[b]),
      .shift_en (shift_vec[b])
    );
  end

  gsr_outmux #(.WIDTH(WIDTH), .BANKS(BANKS), .AW(AW)) u_mux (
    .tails    (tails),
    .bank_ptr (bank_ptr),
    .sel_tail (sel_tail)
  );

  // Tail of the selected bank, read before that bank shifts on this edge.
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (cap_en)  dout <= sel_tail;
  end

  // R6
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(shift_vec));

  // R4
  dout_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(dout));

  // R5
  dout_clear_chk: assert property (@(posedge clk)
    rst |=> dout == '0);

endmodule

// File: tb/gsr_capture_mem_bench.sv
module gsr_capture_mem_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WIDTH = 12;
  localparam int unsigned BANKS = 8;
  localparam int unsigned DEPTH = 256;
  localparam int unsigned RW    = 4;
  localparam int unsigned NVEC  = 6;
  localparam int unsigned TAIL  = 48;

  // Stimulus table: divider setting, throwaway lead cycles, expected delay.
  localparam int unsigned VEC_DIV  [NVEC] = '{1, 2, 4, 8, 0, 4};
  localparam int unsigned VEC_LEAD [NVEC] = '{0, 3, 5, 1, 7, 11};
  localparam int unsigned VEC_EXP  [NVEC] = '{DEPTH, DEPTH, DEPTH, DEPTH, DEPTH, DEPTH};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cap_en = 1'b0;
  logic [RW-1:0]    step_div = '0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;
  logic [WIDTH-1:0] hist [DEPTH + TAIL + 16];

  always #(CLK_PERIOD/2) clk = ~clk;

  gsr_capture_mem u_gsr_capture_mem (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .step_div (step_div),
    .din      (din),
    .dout     (dout)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next fall.
  task automatic tick(input logic en, input logic [WIDTH-1:0] d);
    cap_en = en;
    din    = d;
    @(negedge clk);
  endtask

  task automatic run_vec(input int unsigned dv, input int unsigned lead,
                         input int unsigned lat, input string req);
    logic [WIDTH-1:0] held;
    step_div = RW'(dv);
    for (int i = 0; i < int'(lead); i++) tick(1'b1, WIDTH'($urandom));
    for (int k = 0; k < int'(lat + TAIL); k++) begin
      hist[k] = WIDTH'($urandom);
      tick(1'b1, hist[k]);
      if (k >= int'(lat)) check(req, dout, hist[k - int'(lat)]);
      if (k == int'(lat) + 10) begin
        held = dout;
        for (int j = 0; j < 5; j++) begin
          tick(1'b0, WIDTH'($urandom));
          check("R4 stall", dout, held);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(1'b0, '0);
    tick(1'b0, '0);
    rst = 1'b0;
    // R5: output cleared by reset
    check("R5 reset", dout, '0);
    // R4: frozen output ignores input while disabled
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, WIDTH'($urandom));
      check("R4 idle", dout, '0);
    end

    for (int v = 0; v < int'(NVEC); v++) begin
      if (VEC_DIV[v] == 0)      run_vec(VEC_DIV[v], VEC_LEAD[v], VEC_EXP[v], "R3 div0");
      else if (VEC_DIV[v] == BANKS) run_vec(VEC_DIV[v], VEC_LEAD[v], VEC_EXP[v], "R2 divmax");
      else                      run_vec(VEC_DIV[v], VEC_LEAD[v], VEC_EXP[v], "R1 delay");
    end

    // R5: reset after capture clears only the output register
    rst = 1'b1;
    tick(1'b0, '0);
    rst = 1'b0;
    check("R5 reset after data", dout, '0);
    tick(1'b0, '0);
    check("R5 hold after reset", dout, '0);

    // R6 R7: full run after reset, pointer phase left untouched
    run_vec(2, 0, DEPTH, "R6 R7 post-reset delay");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule